// File: doc/BRIEF.md
# Replacement Victim Selector

This block decides which way of a set-associative cache is overwritten when a new line must be brought in. It holds replacement bookkeeping for every set and applies one of five disciplines picked by a parameter: oldest fill first, least recently used, most recently used, a rotating pointer per set, or a pseudo-random draw. A cache controller reports each hit with its set and way, reports each fill with its set and way, and drives a lookup set whose victim way the block returns combinationally from its stored state.

The block keeps its own per-way valid bits, which are set by fills and cleared by reset. Any set that still has an empty way always gets its lowest-numbered empty way as the victim, whatever the discipline. With a single way the block holds no state and always answers way 0. Tag storage, data storage and the controller are outside the block.

Top module: `victim_selector`

## Requirements
- R1: After reset every way of every set is empty, all rotating pointers are 0, and the victim for every set is way 0 under every discipline.
- R2: A fill marks its way valid; while a set has any empty way, the victim is the lowest-numbered empty way, regardless of the discipline.
- R3: Oldest-fill discipline (POLICY FIFO): in a full set the victim is the way whose latest fill is earliest; hits never change the choice.
- R4: Least-recent discipline (POLICY LRU): in a full set the victim is the way whose latest hit or fill is earliest.
- R5: Most-recent discipline (POLICY MRU): in a full set the victim is the way whose latest hit or fill is the newest.
- R6: Rotating discipline (POLICY RR): each set has a pointer, reset to 0, that is the victim of a full set; every fill into the set advances it by one modulo the way count, whichever way was filled.
- R7: Random discipline (POLICY RAND): a 16-bit register is loaded with 16'hACE1 during reset and on every clock out of reset is shifted right by one, then XORed with 16'hB400 if the bit shifted out was 1; the victim of a full set is its current value modulo the way count, and it is never zero.
- R8: With one way (WAYS = 1) the victim is always way 0.
- R9: When a hit and a fill are strobed in the same cycle, only the fill updates replacement state; the hit is dropped.
- R10: State changes at the clock edge that samples a strobe, and the victim for look_set reflects that new state from that edge on, with no further delay.
- R11: Hits and fills to one set leave the victim of every other set unchanged.
- R12: The victim is always less than the way count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A hit occurred this cycle |
| hit_set | input | SET_W | Set of the hit |
| hit_way | input | WAY_W | Way that hit |
| fill_valid | input | 1 | A line is being written into the cache this cycle |
| fill_set | input | SET_W | Set receiving the fill |
| fill_way | input | WAY_W | Way receiving the fill |
| look_set | input | SET_W | Set whose victim is requested |
| victim_way | output | WAY_W | Way to evict from look_set |

## Verification
Every result is due zero cycles after the edge that samples its strobe: a hit or fill captured at an edge shows on victim_way for look_set straight after that edge, while a change of look_set alone shows within the same cycle. The bench drives all inputs on the falling edge, waits one nanosecond and then compares victim_way with a model that it updates on the rising edge, so each comparison sees exactly the state left by all strobes sampled so far. The model keeps fill and touch timestamps, rotating pointers and its own copy of the random register, so the orderings of R3 to R7 are checked without any use of age counters.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef enum logic [2:0] {
        POL_FIFO = 3'd0,
        POL_LRU  = 3'd1,
        POL_MRU  = 3'd2,
        POL_RR   = 3'd3,
        POL_RAND = 3'd4
    } policy_e;

    localparam int           RND_W    = 16;
    localparam logic [15:0]  RND_SEED = 16'hACE1;
    localparam logic [15:0]  RND_TAPS = 16'hB400;

    // index width that never collapses to zero bits
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // one right-shift step of the Galois register
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] v);
        return v[0] ? ((v >> 1) ^ RND_TAPS) : (v >> 1);
    endfunction

endpackage

// File: rtl/vsel_lfsr.sv
module vsel_lfsr
    import vsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [RND_W-1:0] state_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RND_SEED;
        end else begin
            state_q <= rnd_step(state_q);
        end
    end

endmodule

// File: rtl/vsel_age_table.sv
module vsel_age_table
    import vsel_pkg::*;
#(
    parameter  int SETS  = 16,
    parameter  int WAYS  = 4,
    localparam int SET_W = idx_w(SETS),
    localparam int AGE_W = idx_w(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd_en,
    input  logic [SET_W-1:0]           upd_set,
    input  logic [AGE_W-1:0]           upd_way,
    input  logic [SET_W-1:0]           rd_set,
    output logic [WAYS-1:0][AGE_W-1:0] rd_age
);

    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

    logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];
    logic [AGE_W-1:0]           ref_age;

    // rank of the touched way before this update
    always_comb ref_age = age_q[upd_set][upd_way];

    assign rd_age = age_q[rd_set];

    // ages stay a strict order among touched ways; untouched ways sit at AGE_MAX
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= AGE_MAX;
                end
            end
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (AGE_W'(w) == upd_way) begin
                    age_q[upd_set][w] <= '0;
                end else if (age_q[upd_set][w] < ref_age) begin
                    age_q[upd_set][w] <= age_q[upd_set][w] + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vsel_rr_table.sv
module vsel_rr_table
    import vsel_pkg::*;
#(
    parameter  int SETS  = 16,
    parameter  int WAYS  = 4,
    localparam int SET_W = idx_w(SETS),
    localparam int WAY_W = idx_w(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_en,
    input  logic [SET_W-1:0] adv_set,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_ptr
);

    localparam logic [WAY_W-1:0] LAST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] ptr_q [SETS];

    assign rd_ptr = ptr_q[rd_set];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                ptr_q[s] <= '0;
            end
        end else if (adv_en) begin
            ptr_q[adv_set] <= (ptr_q[adv_set] == LAST) ? '0 : ptr_q[adv_set] + 1'b1;
        end
    end

endmodule

// File: rtl/vsel_rank.sv
module vsel_rank
    import vsel_pkg::*;
#(
    parameter  int WAYS       = 4,
    parameter  bit PICK_OLDEST = 1'b1,
    localparam int WAY_W      = idx_w(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] ages,
    output logic [WAY_W-1:0]           way
);

    // strict compare keeps the lowest index on a tie
    always_comb begin
        way = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (PICK_OLDEST) begin
                if (ages[w] > ages[way]) way = WAY_W'(w);
            end else begin
                if (ages[w] < ages[way]) way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/vsel_pick.sv
module vsel_pick
    import vsel_pkg::*;
#(
    parameter  int WAYS  = 4,
    localparam int WAY_W = idx_w(WAYS)
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAY_W-1:0] cand,
    output logic [WAY_W-1:0] victim
);

    // descending scan so the lowest empty way is the last one written
    always_comb begin
        victim = cand;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) victim = WAY_W'(w);
        end
    end

endmodule

// File: rtl/victim_selector.sv
module victim_selector
    import vsel_pkg::*;
#(
    parameter  int      SETS   = 16,
    parameter  int      WAYS   = 4,
    parameter  policy_e POLICY = POL_LRU,
    localparam int      SET_W  = idx_w(SETS),
    localparam int      WAY_W  = idx_w(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_valid,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [SET_W-1:0] look_set,
    output logic [WAY_W-1:0] victim_way
);

    logic [WAYS-1:0] look_valid;

    if (WAYS == 1) begin : g_direct
        assign look_valid = '1;
        assign victim_way = '0;
    end else begin : g_assoc
        logic [WAYS-1:0]  valid_q [SETS];
        logic [WAY_W-1:0] cand;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) begin
                    valid_q[s] <= '0;
                end
            end else if (fill_valid) begin
                valid_q[fill_set][fill_way] <= 1'b1;
            end
        end

        assign look_valid = valid_q[look_set];

        if (POLICY == POL_RR) begin : g_rr
            vsel_rr_table #(.SETS(SETS), .WAYS(WAYS)) u_ptr (
                .clk    (clk),
                .rst    (rst),
                .adv_en (fill_valid),
                .adv_set(fill_set),
                .rd_set (look_set),
                .rd_ptr (cand)
            );
        end else if (POLICY == POL_RAND) begin : g_rand
            logic [RND_W-1:0] rnd_q;
            vsel_lfsr u_rnd (
                .clk    (clk),
                .rst    (rst),
                .state_q(rnd_q)
            );
            assign cand = WAY_W'(rnd_q % RND_W'(WAYS));
        end else begin : g_age
            localparam bit COUNT_HITS = (POLICY != POL_FIFO);
            logic                       upd_en;
            logic [SET_W-1:0]           upd_set;
            logic [WAY_W-1:0]           upd_way;
            logic [WAYS-1:0][WAY_W-1:0] ages;

            // a fill outranks a hit in the same cycle
            assign upd_en  = fill_valid | (hit_valid & COUNT_HITS);
            assign upd_set = fill_valid ? fill_set : hit_set;
            assign upd_way = fill_valid ? fill_way : hit_way;

            vsel_age_table #(.SETS(SETS), .WAYS(WAYS)) u_age (
                .clk    (clk),
                .rst    (rst),
                .upd_en (upd_en),
                .upd_set(upd_set),
                .upd_way(upd_way),
                .rd_set (look_set),
                .rd_age (ages)
            );

            vsel_rank #(.WAYS(WAYS), .PICK_OLDEST(POLICY != POL_MRU)) u_rank (
                .ages(ages),
                .way (cand)
            );
        end

        vsel_pick #(.WAYS(WAYS)) u_pick (
            .valid (look_valid),
            .cand  (cand),
            .victim(victim_way)
        );
    end

endmodule

// File: rtl/vsel_checker.sv
module vsel_checker
    import vsel_pkg::*;
#(
    parameter  int      SETS   = 16,
    parameter  int      WAYS   = 4,
    parameter  policy_e POLICY = POL_LRU,
    localparam int      SET_W  = idx_w(SETS),
    localparam int      WAY_W  = idx_w(WAYS)
) (
    input logic             clk,
    input logic             rst,
    input logic             hit_valid,
    input logic [SET_W-1:0] hit_set,
    input logic [WAY_W-1:0] hit_way,
    input logic             fill_valid,
    input logic [SET_W-1:0] fill_set,
    input logic [WAY_W-1:0] fill_way,
    input logic [SET_W-1:0] look_set,
    input logic [WAYS-1:0]  look_valid,
    input logic [WAY_W-1:0] victim_way
);

    a_r12_victim_range: assert property (@(posedge clk) disable iff (rst)
        int'(victim_way) < WAYS);

    if (WAYS > 1) begin : g_multi
        a_r2_empty_way_chosen: assert property (@(posedge clk) disable iff (rst)
            (look_valid != '1) |-> !look_valid[victim_way]);

        a_r2_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
            (fill_valid && fill_set == look_set)
            |=> ($stable(look_set) -> look_valid[$past(fill_way)]));

        if (POLICY == POL_LRU) begin : g_lru
            a_r4_hit_not_victim: assert property (@(posedge clk) disable iff (rst)
                (hit_valid && !fill_valid && hit_set == look_set && (&look_valid))
                |=> ($stable(look_set) -> victim_way != $past(hit_way)));
        end

        if (POLICY == POL_MRU) begin : g_mru
            a_r5_hit_is_victim: assert property (@(posedge clk) disable iff (rst)
                (hit_valid && !fill_valid && hit_set == look_set && (&look_valid))
                |=> ($stable(look_set) -> victim_way == $past(hit_way)));
        end

        if (POLICY == POL_FIFO) begin : g_fifo
            a_r3_hit_ignored: assert property (@(posedge clk) disable iff (rst)
                (hit_valid && !fill_valid)
                |=> ($stable(look_set) -> $stable(victim_way)));
        end

        if (POLICY == POL_RR) begin : g_rr
            a_r6_pointer_steps: assert property (@(posedge clk) disable iff (rst)
                (fill_valid && fill_set == look_set && (&look_valid))
                |=> ($stable(look_set) ->
                     int'(victim_way) == (int'($past(victim_way)) + 1) % WAYS));
        end
    end

endmodule

bind victim_selector vsel_checker #(
    .SETS  (SETS),
    .WAYS  (WAYS),
    .POLICY(POLICY)
) u_vsel_checker (
    .clk       (clk),
    .rst       (rst),
    .hit_valid (hit_valid),
    .hit_set   (hit_set),
    .hit_way   (hit_way),
    .fill_valid(fill_valid),
    .fill_set  (fill_set),
    .fill_way  (fill_way),
    .look_set  (look_set),
    .look_valid(look_valid),
    .victim_way(victim_way)
);

// File: tb/test_victim_selector.sv
`timescale 1ns/1ps
module test_victim_selector;
    import vsel_pkg::*;

    localparam int NS = 4;
    localparam int NW = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hit_valid = 1'b0, fill_valid = 1'b0;
    logic [1:0] hit_set = '0, hit_way = '0, fill_set = '0, fill_way = '0, look_set = '0;
    logic [1:0] vic [5];
    logic [0:0] vic_dm;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar p = 0; p < 5; p++) begin : g_pol
        victim_selector #(.SETS(NS), .WAYS(NW), .POLICY(policy_e'(p))) i_victim_selector (
            .clk(clk), .rst(rst),
            .hit_valid(hit_valid), .hit_set(hit_set), .hit_way(hit_way),
            .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
            .look_set(look_set), .victim_way(vic[p])
        );
    end

    if (1) begin : g_dm
        victim_selector #(.SETS(NS), .WAYS(1), .POLICY(POL_FIFO)) i_victim_selector (
            .clk(clk), .rst(rst),
            .hit_valid(hit_valid), .hit_set(hit_set), .hit_way(hit_way[0:0]),
            .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way[0:0]),
            .look_set(look_set), .victim_way(vic_dm)
        );
    end

    // reference model built from the requirements
    int          tick;
    int          t_touch [NS][NW];
    int          t_fill  [NS][NW];
    bit          m_vld   [NS][NW];
    int          m_ptr   [NS];
    logic [15:0] m_rnd;

    always @(posedge clk) begin
        if (rst) begin
            tick  = 0;
            m_rnd = 16'hACE1;
            for (int s = 0; s < NS; s++) begin
                m_ptr[s] = 0;
                for (int w = 0; w < NW; w++) begin
                    m_vld[s][w] = 1'b0; t_touch[s][w] = 0; t_fill[s][w] = 0;
                end
            end
        end else begin
            tick++;
            m_rnd = m_rnd[0] ? ((m_rnd >> 1) ^ 16'hB400) : (m_rnd >> 1);
            if (fill_valid) begin
                m_vld[fill_set][fill_way]   = 1'b1;
                t_touch[fill_set][fill_way] = tick;
                t_fill[fill_set][fill_way]  = tick;
                m_ptr[fill_set] = (m_ptr[fill_set] + 1) % NW;
            end else if (hit_valid) begin
                t_touch[hit_set][hit_way] = tick;
            end
        end
    end

    function automatic int first_empty(int s);
        for (int w = 0; w < NW; w++) if (!m_vld[s][w]) return w;
        return -1;
    endfunction

    function automatic int expect_vic(int p, int s);
        int best = 0;
        if (first_empty(s) >= 0) return first_empty(s);
        case (p)
            0: for (int w = 1; w < NW; w++) if (t_fill[s][w]  < t_fill[s][best])  best = w;
            1: for (int w = 1; w < NW; w++) if (t_touch[s][w] < t_touch[s][best]) best = w;
            2: for (int w = 1; w < NW; w++) if (t_touch[s][w] > t_touch[s][best]) best = w;
            3: best = m_ptr[s];
            default: best = int'(m_rnd % 16'(NW));
        endcase
        return best;
    endfunction

    function automatic string tag_of(int p, int s);
        if (first_empty(s) >= 0) return "R2";
        case (p)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FIFO? no: FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int p = 0; p < 5; p++) begin
            check(int'(vic[p]) == expect_vic(p, look_set), tag_of(p, look_set),
                  int'(vic[p]), expect_vic(p, look_set));
        end
        check(int'(vic[4]) < NW, "R12", int'(vic[4]), NW - 1);
        check(m_rnd != 16'h0, "R7", int'(m_rnd), 1);
        check(vic_dm == 1'b0, "R8", int'(vic_dm), 0);
    endtask

    task automatic drive(bit hv, int hs, int hw, bit fv, int fs, int fw, int ls);
        @(negedge clk);
        hit_valid  = hv;  hit_set  = 2'(hs); hit_way  = 2'(hw);
        fill_valid = fv;  fill_set = 2'(fs); fill_way = 2'(fw);
        look_set   = 2'(ls);
        #1;
        compare_all();
    endtask

    initial begin
        int keep [5];
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every set answers way 0 after reset
        for (int s = 0; s < NS; s++) begin
            drive(0, 0, 0, 0, 0, 0, s);
            for (int p = 0; p < 5; p++) check(vic[p] == 2'd0, "R1", int'(vic[p]), 0);
        end

        // R10: a fill shows on the very next sample
        drive(0, 0, 0, 1, 2, 0, 2);
        drive(0, 0, 0, 0, 0, 0, 2);
        check(vic[0] == 2'd1, "R10", int'(vic[0]), 1);

        // R9: fill set 3 in order, then a fill and a hit together
        for (int w = 0; w < NW; w++) drive(0, 0, 0, 1, 3, w, 3);
        drive(1, 3, 1, 1, 3, 0, 3);
        drive(0, 0, 0, 0, 0, 0, 3);
        check(vic[1] == 2'd1, "R9", int'(vic[1]), 1);

        // R11: activity in set 1 leaves set 0 alone
        for (int w = NW - 1; w >= 0; w--) drive(0, 0, 0, 1, 0, w, 0);
        drive(1, 0, 2, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        for (int p = 0; p < 4; p++) keep[p] = int'(vic[p]);
        for (int w = 0; w < NW; w++) drive(1, 1, 3 - w, 1, 1, w, 0);
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        for (int p = 0; p < 4; p++) check(int'(vic[p]) == keep[p], "R11", int'(vic[p]), keep[p]);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 100) < 50, $urandom % NS, $urandom % NW,
                  ($urandom % 100) < 25, $urandom % NS, $urandom % NW, $urandom % NS);
        end

        // R1 again after a mid-run reset
        @(negedge clk); rst = 1'b1;
        hit_valid = 1'b0; fill_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < NS; s++) begin
            drive(0, 0, 0, 0, 0, 0, s);
            for (int p = 0; p < 5; p++) check(vic[p] == 2'd0, "R1", int'(vic[p]), 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule